// File: doc/BRIEF.md
# Row-to-Row Label Translation and Index Updater

This block keeps the label bookkeeping for a streaming connected-components engine that handles one pixel per clock with no gap between image rows. A run detector upstream classifies pixels. It sends this block one event per clock at most: a current run touches a run of the previous row (overlap), two previous-row runs turn out to belong to the same region (equivalence), a run has ended, or the row has ended. Labels are recycled every row. Previous-row labels pass through a per-row translation table to current-row labels. Each label has an index entry that names its representative. Each representative owns a feature record holding area, column sum and row sum.

Every event is accepted on the clock it arrives, so the block never stalls. Every event also returns the current-row label it resolved to, at a fixed distance of four clocks. On row end, the current index and feature tables become the previous ones. The current tables, the translation table and the label counter then start again from zero. A downstream analyser reads previous-row results through a registered query port. All tables hold half as many entries as the image has columns, which is the largest number of runs a row can contain.

Top module: `lbl_xlate_top`

## Requirements
- R1: After reset, `rsp_vld` is 0, and a query of any label L returns representative L with an all-zero feature record.
- R2: Every accepted event gives exactly one response, four clocks after the event is sampled. Events may arrive on consecutive clocks, and a clock without an event gives no response. Event kind encoding: 0 = overlap, 1 = equivalence, 2 = run end, 3 = row end.
- R3: An overlap on previous label `ev_a` whose previous representative has no translation allocates the next current label, counting from 1. It records that translation and copies the representative's previous feature record into the new label. The new label is the response.
- R4: An overlap whose representative is already translated allocates nothing. The response is the current representative of the translated label.
- R5: The previous representative of label L is L itself when L's previous index entry is 0, and otherwise is the entry's value. Queries (`q_lbl` → `q_rep`, `q_feat` one clock later) report this representative and its feature record.
- R6: A run end with `ev_joined` = 0 allocates the next label and stores `ev_feat` as its record. The feature packing is area in bits [47:32], column sum in [31:16] and row sum in [15:0]; each field adds modulo 2^16.
- R7: A run end with `ev_joined` = 1 adds `ev_feat` into the record of the current representative of label `ev_b` and responds with that representative.
- R8: An equivalence between `ev_a` and `ev_b` whose representatives are both translated, to different current representatives, points the larger label at the smaller one. It adds the larger label's record into the smaller one's record and responds with the smaller label.
- R9: An equivalence where only one side is translated attaches the other side's representative to that translation and adds its previous record in. When neither side is translated, one new label is allocated, both are mapped to it, and it receives the sum of their distinct previous records.
- R10: A row end makes the current index and feature tables the previous ones. It clears the current tables and the translation table, restarts label counting at 1, and responds with label 0.
- R11: Once all COLS/2 labels of a row are in use, an event that needs a new label responds with 0 and changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_vld | input | 1 | Event present this clock |
| ev_kind | input | 2 | Event kind (0 overlap, 1 equivalence, 2 run end, 3 row end) |
| ev_a | input | LBL_W | Previous-row label (overlap, equivalence) |
| ev_b | input | LBL_W | Second previous-row label (equivalence) or current label (joined run end) |
| ev_joined | input | 1 | Run end: 0 = new run, 1 = run joined to a translated label |
| ev_feat | input | 48 | Accumulated run features {area, column sum, row sum} |
| q_lbl | input | LBL_W | Previous-row label to query |
| q_rep | output | LBL_W | Previous representative of `q_lbl` (one clock later) |
| q_feat | output | 48 | Feature record of that representative |
| rsp_vld | output | 1 | Response present |
| rsp_lbl | output | LBL_W | Current-row label the event resolved to (0 if none) |

## Verification
Each event's response is due exactly four clocks after the edge that samples it. The bench queues every expected label with the cycle it falls due. On every falling edge it compares `rsp_vld` and `rsp_lbl` with the queue head, or expects silence when nothing is due. Table changes are committed two edges after an event. For that reason, query checks are made only after at least six idle clocks, and they are sampled one clock after `q_lbl` is applied. The expected values come from a behavioural model that follows index chains of any depth, not the flat single-level pointers the design keeps.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  parameter int FEAT_W = 16;

  typedef enum logic [1:0] {
    K_OVL = 2'd0,
    K_EQU = 2'd1,
    K_RUN = 2'd2,
    K_ROW = 2'd3
  } kind_e;

  typedef struct packed {
    logic [FEAT_W-1:0] area;
    logic [FEAT_W-1:0] sum_x;
    logic [FEAT_W-1:0] sum_y;
  } feat_t;

  // field-wise wrap-around sum of two feature records
  function automatic feat_t feat_sum(input feat_t a, input feat_t b);
    feat_t r;
    r.area  = a.area  + b.area;
    r.sum_x = a.sum_x + b.sum_x;
    r.sum_y = a.sum_y + b.sum_y;
    return r;
  endfunction

endpackage

// File: rtl/lbl_evt_reg.sv
module lbl_evt_reg
  import lbl_pkg::*;
#(
  parameter int LBL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_vld,
  input  kind_e            i_kind,
  input  logic [LBL_W-1:0] i_a,
  input  logic [LBL_W-1:0] i_b,
  input  logic             i_joined,
  input  feat_t            i_feat,
  output logic             o_vld,
  output kind_e            o_kind,
  output logic [LBL_W-1:0] o_a,
  output logic [LBL_W-1:0] o_b,
  output logic             o_joined,
  output feat_t            o_feat
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld    <= 1'b0;
      o_kind   <= K_OVL;
      o_a      <= '0;
      o_b      <= '0;
      o_joined <= 1'b0;
      o_feat   <= '0;
    end else begin
      o_vld    <= i_vld;
      o_kind   <= i_kind;
      o_a      <= i_a;
      o_b      <= i_b;
      o_joined <= i_joined;
      o_feat   <= i_feat;
    end
  end

endmodule

// File: rtl/lbl_table_core.sv
module lbl_table_core
  import lbl_pkg::*;
#(
  parameter int N     = 16,
  parameter int LBL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_vld,
  input  kind_e            s_kind,
  input  logic [LBL_W-1:0] s_a,
  input  logic [LBL_W-1:0] s_b,
  input  logic             s_joined,
  input  feat_t            s_feat,
  input  logic [LBL_W-1:0] q_lbl,
  output logic [LBL_W-1:0] q_rep,
  output feat_t            q_feat,
  output logic             c_vld,
  output logic [LBL_W-1:0] c_lbl
);

  localparam logic [LBL_W-1:0] NMAX = LBL_W'(N);

  // storage: slot 0 unused, label 0 means "none"
  logic [LBL_W-1:0] prev_idx [0:N];
  logic [LBL_W-1:0] cur_idx  [0:N];
  logic [LBL_W-1:0] xmap     [0:N];
  feat_t            prev_dat [0:N];
  feat_t            cur_dat  [0:N];
  logic [LBL_W-1:0] cnt;

  function automatic logic [LBL_W-1:0] root_of(input logic [LBL_W-1:0] ptr,
                                               input logic [LBL_W-1:0] lbl);
    return (ptr == '0) ? lbl : ptr;
  endfunction

  // lookup layers
  logic [LBL_W-1:0] ra, rb, ma, mb, ka, kb, kj, lo, hi, nxt, qr;
  logic             full;

  always_comb begin
    ra   = root_of(prev_idx[s_a], s_a);
    rb   = root_of(prev_idx[s_b], s_b);
    ma   = xmap[ra];
    mb   = xmap[rb];
    ka   = (ma == '0) ? '0 : root_of(cur_idx[ma], ma);
    kb   = (mb == '0) ? '0 : root_of(cur_idx[mb], mb);
    kj   = root_of(cur_idx[s_b], s_b);
    lo   = (ka < kb) ? ka : kb;
    hi   = (ka < kb) ? kb : ka;
    full = (cnt == NMAX);
    nxt  = cnt + LBL_W'(1);
    qr   = root_of(prev_idx[q_lbl], q_lbl);
  end

  // named internal events
  logic             ev_alloc, ev_attach_a, ev_attach_b, ev_merge, ev_join, ev_row;
  logic [LBL_W-1:0] res;
  feat_t            alloc_feat;

  always_comb begin
    ev_alloc    = 1'b0;
    ev_attach_a = 1'b0;
    ev_attach_b = 1'b0;
    ev_merge    = 1'b0;
    ev_join     = 1'b0;
    ev_row      = 1'b0;
    res         = '0;
    alloc_feat  = s_feat;
    if (s_vld) begin
      unique case (s_kind)
        K_OVL: begin
          alloc_feat = prev_dat[ra];
          if (ma != '0) res = ka;
          else if (!full) begin
            ev_alloc = 1'b1;
            res      = nxt;
          end
        end
        K_EQU: begin
          alloc_feat = (ra == rb) ? prev_dat[ra] : feat_sum(prev_dat[ra], prev_dat[rb]);
          if (ka == '0 && kb == '0) begin
            if (!full) begin
              ev_alloc = 1'b1;
              res      = nxt;
            end
          end else if (ka == '0) begin
            ev_attach_a = 1'b1;
            res         = kb;
          end else if (kb == '0) begin
            ev_attach_b = 1'b1;
            res         = ka;
          end else begin
            ev_merge = (ka != kb);
            res      = lo;
          end
        end
        K_RUN: begin
          if (s_joined) begin
            ev_join = 1'b1;
            res     = kj;
          end else if (!full) begin
            ev_alloc = 1'b1;
            res      = nxt;
          end
        end
        K_ROW: ev_row = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= N; i++) begin
        prev_idx[i] <= '0;
        cur_idx[i]  <= '0;
        xmap[i]     <= '0;
        prev_dat[i] <= '0;
        cur_dat[i]  <= '0;
      end
      cnt    <= '0;
      c_vld  <= 1'b0;
      c_lbl  <= '0;
      q_rep  <= '0;
      q_feat <= '0;
    end else begin
      c_vld  <= s_vld;
      c_lbl  <= res;
      q_rep  <= qr;
      q_feat <= prev_dat[qr];
      if (ev_row) begin
        for (int i = 0; i <= N; i++) begin
          prev_idx[i] <= cur_idx[i];
          prev_dat[i] <= cur_dat[i];
          cur_idx[i]  <= '0;
          cur_dat[i]  <= '0;
          xmap[i]     <= '0;
        end
        cnt <= '0;
      end else begin
        if (ev_alloc) begin
          cnt          <= nxt;
          cur_dat[nxt] <= alloc_feat;
          if (s_kind != K_RUN) xmap[ra] <= nxt;
          if (s_kind == K_EQU) xmap[rb] <= nxt;
        end
        if (ev_attach_a) begin
          xmap[ra]    <= kb;
          cur_dat[kb] <= feat_sum(cur_dat[kb], prev_dat[ra]);
        end
        if (ev_attach_b) begin
          xmap[rb]    <= ka;
          cur_dat[ka] <= feat_sum(cur_dat[ka], prev_dat[rb]);
        end
        if (ev_merge) begin
          for (int i = 1; i <= N; i++)
            if (cur_idx[i] == hi) cur_idx[i] <= lo;
          cur_idx[hi] <= lo;
          cur_dat[lo] <= feat_sum(cur_dat[lo], cur_dat[hi]);
        end
        if (ev_join) cur_dat[kj] <= feat_sum(cur_dat[kj], s_feat);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NMAX);

  assert_full_no_alloc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_kind == K_RUN && !s_joined && cnt == NMAX) |=> (cnt == NMAX && c_lbl == '0));

  assert_new_run_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_kind == K_RUN && !s_joined && cnt != NMAX) |=> (cnt == $past(cnt) + LBL_W'(1)));

  assert_row_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_kind == K_ROW) |=> (cnt == '0 && c_lbl == '0));

  assert_rsp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> (c_lbl <= NMAX));

  for (genvar g = 1; g <= N; g++) begin : g_idx_chk
    assert_idx_smaller_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx[g] == '0) || (cur_idx[g] < LBL_W'(g)));
  end

endmodule

// File: rtl/lbl_rsp_pipe.sv
module lbl_rsp_pipe #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_vld,
  input  logic [W-1:0] i_dat,
  output logic         o_vld,
  output logic [W-1:0] o_dat
);

  if (STAGES == 0) begin : g_pass
    assign o_vld = i_vld;
    assign o_dat = i_dat;
  end else begin : g_chain
    logic [W:0] st [STAGES];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
        st[0] <= {i_vld, i_dat};
        for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
    end
    assign o_vld = st[STAGES-1][W];
    assign o_dat = st[STAGES-1][W-1:0];
  end

endmodule

// File: rtl/lbl_xlate_top.sv
module lbl_xlate_top
  import lbl_pkg::*;
#(
  parameter  int COLS  = 32,
  localparam int N     = COLS / 2,
  localparam int LBL_W = $clog2(N + 1),
  localparam int FW3   = 3 * FEAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vld,
  input  logic [1:0]       ev_kind,
  input  logic [LBL_W-1:0] ev_a,
  input  logic [LBL_W-1:0] ev_b,
  input  logic             ev_joined,
  input  logic [FW3-1:0]   ev_feat,
  input  logic [LBL_W-1:0] q_lbl,
  output logic [LBL_W-1:0] q_rep,
  output logic [FW3-1:0]   q_feat,
  output logic             rsp_vld,
  output logic [LBL_W-1:0] rsp_lbl
);

  localparam int LATENCY    = 4;
  localparam int TAIL_STAGE = LATENCY - 2;

  logic             s_vld, s_joined, c_vld;
  kind_e            s_kind;
  logic [LBL_W-1:0] s_a, s_b, c_lbl;
  feat_t            s_feat, q_feat_s;

  lbl_evt_reg #(.LBL_W(LBL_W)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .i_vld(ev_vld), .i_kind(kind_e'(ev_kind)), .i_a(ev_a), .i_b(ev_b),
    .i_joined(ev_joined), .i_feat(feat_t'(ev_feat)),
    .o_vld(s_vld), .o_kind(s_kind), .o_a(s_a), .o_b(s_b),
    .o_joined(s_joined), .o_feat(s_feat)
  );

  lbl_table_core #(.N(N), .LBL_W(LBL_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_vld(s_vld), .s_kind(s_kind), .s_a(s_a), .s_b(s_b),
    .s_joined(s_joined), .s_feat(s_feat),
    .q_lbl(q_lbl), .q_rep(q_rep), .q_feat(q_feat_s),
    .c_vld(c_vld), .c_lbl(c_lbl)
  );

  lbl_rsp_pipe #(.W(LBL_W), .STAGES(TAIL_STAGE)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .i_vld(c_vld), .i_dat(c_lbl),
    .o_vld(rsp_vld), .o_dat(rsp_lbl)
  );

  assign q_feat = q_feat_s;

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'(LATENCY)) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'(LATENCY)) |-> (rsp_vld == $past(ev_vld, 4)));

  assert_row_rsp_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'(LATENCY) && $past(ev_vld, 4) && $past(ev_kind, 4) == 2'd3) |-> (rsp_lbl == '0));

endmodule

// File: tb/lbl_xlate_top_tb.sv
module lbl_xlate_top_tb;

  localparam int COLS  = 32;
  localparam int N     = COLS / 2;
  localparam int LBL_W = $clog2(N + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ev_vld = 1'b0;
  logic [1:0]       ev_kind = '0;
  logic [LBL_W-1:0] ev_a = '0, ev_b = '0, q_lbl = '0;
  logic             ev_joined = 1'b0;
  logic [47:0]      ev_feat = '0;
  logic [LBL_W-1:0] q_rep, rsp_lbl;
  logic [47:0]      q_feat;
  logic             rsp_vld;

  lbl_xlate_top #(.COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_kind(ev_kind),
    .ev_a(ev_a), .ev_b(ev_b), .ev_joined(ev_joined), .ev_feat(ev_feat),
    .q_lbl(q_lbl), .q_rep(q_rep), .q_feat(q_feat),
    .rsp_vld(rsp_vld), .rsp_lbl(rsp_lbl)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // ---------------- behavioural reference ----------------
  int          m_pidx [0:N];
  int          m_cidx [0:N];
  int          m_map  [0:N];
  logic [47:0] m_pdat [0:N];
  logic [47:0] m_cdat [0:N];
  int          m_cnt = 0;

  function automatic logic [47:0] fadd(logic [47:0] a, logic [47:0] b);
    logic [15:0] x, y, z;
    x = a[47:32] + b[47:32];
    y = a[31:16] + b[31:16];
    z = a[15:0]  + b[15:0];
    return {x, y, z};
  endfunction

  function automatic int prep(int l);
    int r = l;
    while (m_pidx[r] != 0) r = m_pidx[r];
    return r;
  endfunction

  function automatic int crep(int l);
    int r = l;
    while (m_cidx[r] != 0) r = m_cidx[r];
    return r;
  endfunction

  function automatic int model(int kind, int a, int b, bit j, logic [47:0] f);
    int ra, rb, ka, kb, s, l, k;
    if (kind == 3) begin
      for (int i = 0; i <= N; i++) begin
        m_pidx[i] = m_cidx[i]; m_pdat[i] = m_cdat[i];
        m_cidx[i] = 0; m_cdat[i] = '0; m_map[i] = 0;
      end
      m_cnt = 0;
      return 0;
    end
    if (kind == 2) begin
      if (j) begin
        k = crep(b); m_cdat[k] = fadd(m_cdat[k], f); return k;
      end
      if (m_cnt == N) return 0;
      m_cnt++; m_cdat[m_cnt] = f; return m_cnt;
    end
    ra = prep(a);
    if (kind == 0) begin
      if (m_map[ra] != 0) return crep(m_map[ra]);
      if (m_cnt == N) return 0;
      m_cnt++; m_map[ra] = m_cnt; m_cdat[m_cnt] = m_pdat[ra]; return m_cnt;
    end
    rb = prep(b);
    ka = (m_map[ra] != 0) ? crep(m_map[ra]) : 0;
    kb = (m_map[rb] != 0) ? crep(m_map[rb]) : 0;
    if (ka == 0 && kb == 0) begin
      if (m_cnt == N) return 0;
      m_cnt++;
      m_map[ra] = m_cnt; m_map[rb] = m_cnt;
      m_cdat[m_cnt] = (ra == rb) ? m_pdat[ra] : fadd(m_pdat[ra], m_pdat[rb]);
      return m_cnt;
    end
    if (ka == 0) begin m_map[ra] = kb; m_cdat[kb] = fadd(m_cdat[kb], m_pdat[ra]); return kb; end
    if (kb == 0) begin m_map[rb] = ka; m_cdat[ka] = fadd(m_cdat[ka], m_pdat[rb]); return ka; end
    if (ka == kb) return ka;
    s = (ka < kb) ? ka : kb;
    l = (ka < kb) ? kb : ka;
    m_cidx[l] = s;
    m_cdat[s] = fadd(m_cdat[s], m_cdat[l]);
    return s;
  endfunction

  // ---------------- response scoreboard ----------------
  int    due_q[$];
  int    lbl_q[$];
  string req_q[$];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (due_q.size() != 0 && due_q[0] == cyc) begin
        if (!(rsp_vld === 1'b1 && rsp_lbl === LBL_W'(lbl_q[0]))) begin
          n_fail++;
          $display("FAIL %s response cyc %0d: got vld=%0b lbl=%0d, expected vld=1 lbl=%0d",
                   req_q[0], cyc, rsp_vld, rsp_lbl, lbl_q[0]);
        end
        void'(due_q.pop_front()); void'(lbl_q.pop_front()); void'(req_q.pop_front());
      end else if (rsp_vld !== 1'b0) begin
        n_fail++;
        $display("FAIL R2 idle cyc %0d: got vld=%0b, expected vld=0", cyc, rsp_vld);
      end
    end
  end

  // drive one event at a falling edge; it is sampled at the next rising edge
  task automatic send(int kind, int a, int b, bit j, logic [47:0] f, string req);
    int r;
    ev_vld = 1'b1; ev_kind = 2'(kind); ev_a = LBL_W'(a); ev_b = LBL_W'(b);
    ev_joined = j; ev_feat = f;
    r = model(kind, a, b, j, f);
    due_q.push_back(cyc + 4); lbl_q.push_back(r); req_q.push_back(req);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    ev_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic query(int l, string req);
    int r;
    q_lbl = LBL_W'(l);
    @(negedge clk);
    r = prep(l);
    n_chk++;
    if (q_rep !== LBL_W'(r) || q_feat !== m_pdat[r]) begin
      n_fail++;
      $display("FAIL %s query %0d: got rep=%0d feat=%h, expected rep=%0d feat=%h",
               req, l, q_rep, q_feat, r, m_pdat[r]);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog expired: got hang, expected completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i <= N; i++) begin
      m_pidx[i] = 0; m_cidx[i] = 0; m_map[i] = 0; m_pdat[i] = '0; m_cdat[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state through the query port
    query(5, "R1");
    query(1, "R1");

    // row 0: fresh runs (R6), then a joined run end (R7), back to back
    send(2, 0, 0, 0, {16'd3, 16'd10, 16'd0}, "R6");
    send(2, 0, 0, 0, {16'd2, 16'd20, 16'd0}, "R6");
    send(2, 0, 0, 0, {16'd4, 16'd30, 16'd0}, "R6");
    send(2, 0, 2, 1, {16'd1, 16'd7,  16'd0}, "R7");
    send(3, 0, 0, 0, '0, "R10");
    idle(6);
    query(1, "R10"); query(2, "R7"); query(3, "R5"); query(4, "R10");

    // row 1: overlaps (R3, R4), merge (R8), attach (R9)
    send(0, 1, 0, 0, '0, "R3");
    send(0, 1, 0, 0, '0, "R4");
    send(0, 3, 0, 0, '0, "R3");
    send(1, 1, 3, 0, '0, "R8");
    send(2, 0, 2, 1, {16'd5, 16'd5, 16'd1}, "R7");
    send(1, 2, 1, 0, '0, "R9");
    send(0, 3, 0, 0, '0, "R4");
    send(3, 0, 0, 0, '0, "R10");
    idle(6);
    query(1, "R8"); query(2, "R5"); query(3, "R10");

    // row 2: both unmapped equivalence (R9), then exhaust labels (R11)
    send(1, 1, 2, 0, '0, "R9");
    for (int i = 0; i < N - 1; i++) send(2, 0, 0, 0, {16'd1, 16'(i), 16'd2}, "R6");
    send(2, 0, 0, 0, {16'd9, 16'd9, 16'd9}, "R11");
    send(0, 3, 0, 0, '0, "R11");
    send(3, 0, 0, 0, '0, "R10");
    idle(6);
    query(1, "R9"); query(N, "R11");

    // mixed random traffic with row ends
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 19);
      int kind = (k < 6) ? 0 : (k < 11) ? 1 : (k < 19) ? 2 : 3;
      send(kind, $urandom_range(1, N), $urandom_range(1, N), 1'($urandom_range(0, 1)),
           {16'($urandom_range(1, 9)), 16'($urandom_range(0, 31)), 16'($urandom_range(0, 31))},
           (kind == 1) ? "R8" : (kind == 0) ? "R3" : (kind == 2) ? "R7" : "R10");
    end
    send(3, 0, 0, 0, '0, "R10");
    idle(6);
    for (int l = 1; l <= N; l++) query(l, "R5");
    idle(2);
    summary();
  end

endmodule